// File: doc/BRIEF.md
# Branch History Table Predictor

This block sits beside the instruction fetch stage and acts as a small, fully associative cache of recently resolved branches. Each slot holds the address of a branch, the address it last jumped to, and a two-bit saturating history counter. Every cycle the fetch unit presents its program counter on the lookup port. The table answers in the same cycle with a hit flag, a taken/not-taken guess and the target address, so fetch can redirect without waiting for decode.

When a branch resolves further down the pipeline, the update port reports its address, its target and whether it was taken. A branch already in the table has its counter moved one step toward the outcome and its target refreshed. A branch with no slot is written into the slot named by a round-robin pointer, with its counter set to the weak state that matches the outcome. Flushing the pipe on a wrong guess belongs to the surrounding logic.

Top module: `branch_history_predictor`

## Requirements
- R1: After a synchronous active-low reset every slot is empty, so every lookup reports no hit and not-taken.
- R2: A lookup whose address matches no valid slot reports hit low, taken low and a target of zero, so fetch continues sequentially.
- R3: An update whose address misses writes a new slot with the update's address and target and a counter of 2'b10 (weakly taken) when taken or 2'b01 (weakly not-taken) when not taken.
- R4: An update that hits moves that slot's counter up by one on taken and down by one on not-taken, holding at 2'b11 and at 2'b00.
- R5: On a hit the prediction is taken exactly when bit 1 of the slot's counter is set.
- R6: From a strong state the prediction reverses only after two consecutive outcomes that disagree with it.
- R7: Allocation visits the slots in index order 0,1,...,ENTRIES-1 and wraps; once all are full, a new branch evicts the slot allocated longest ago, and the evicted address then misses.
- R8: When a lookup and an update name the same branch in one cycle, the lookup reports the state held before that update.
- R9: An update that hits replaces the slot's stored target with the update's target.
- R10: At most one slot matches any address, and a lookup hits exactly when a valid slot holds that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched |
| pred_hit | output | 1 | A slot holds fetch_pc |
| pred_taken | output | 1 | Predicted direction for fetch_pc |
| pred_target | output | PC_W | Predicted target, zero on a miss |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_target | input | PC_W | Target of the resolved branch |
| res_taken | input | 1 | Resolved outcome, 1 for taken |

## Verification
The bench builds the table with ENTRIES=4 and PC_W=8. Four slots let a handful of branches fill the table and force wrap-around eviction, and an 8-bit address lets every possible fetch address be looked up after each phase and compared against a model of the table, which covers miss behaviour, tag matching and the absence of duplicate slots across the whole address space. A long outcome pattern on one branch walks the counter through every state and both saturation points.

// File: rtl/bht_pkg.sv
// Shared types and counter arithmetic for the branch history table.
// Assumes the two-bit counter encoding: 00 strong not-taken, 01 weak
// not-taken, 10 weak taken, 11 strong taken.
package bht_pkg;

    typedef logic [1:0] hist_t;

    localparam hist_t HIST_SNT = 2'b00;
    localparam hist_t HIST_WNT = 2'b01;
    localparam hist_t HIST_WT  = 2'b10;
    localparam hist_t HIST_ST  = 2'b11;

    // Step a counter one place toward the resolved outcome, saturating.
    function automatic hist_t hist_step(input hist_t cur, input logic taken);
        hist_t nxt;
        nxt = cur;
        if (taken && cur != HIST_ST)
            nxt = cur + 2'd1;
        else if (!taken && cur != HIST_SNT)
            nxt = cur - 2'd1;
        return nxt;
    endfunction

    // Starting counter for a freshly allocated branch.
    function automatic hist_t hist_seed(input logic taken);
        return taken ? HIST_WT : HIST_WNT;
    endfunction

endpackage

// File: rtl/bht_match.sv
// Compares one address against every slot tag in parallel.
// Assumes the caller keeps tags unique among valid slots.
module bht_match #(
    parameter int ENTRIES = 4,
    parameter int PC_W    = 32
) (
    input  logic [PC_W-1:0]    addr,
    input  logic [PC_W-1:0]    tags  [ENTRIES],
    input  logic [ENTRIES-1:0] valid,
    output logic [ENTRIES-1:0] hit_vec
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        // Per-slot tag comparison qualified by the valid bit.
        assign hit_vec[i] = valid[i] && (tags[i] == addr);
    end

endmodule

// File: rtl/bht_rr_ptr.sv
// Round-robin victim pointer; advances once per allocation and wraps.
// Assumes ENTRIES >= 2.
module bht_rr_ptr #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Step the pointer after each allocation, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (advance)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    assert_rr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

    assert_rr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr));

endmodule

// File: rtl/bht_store.sv
// Slot storage: tag, target, counter and valid for every slot.
// A slot is written either by allocation or by a hit update, never both,
// which the top guarantees because allocation happens only on a miss.
module bht_store #(
    parameter int ENTRIES = 4,
    parameter int PC_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ENTRIES-1:0]  alloc_sel,
    input  logic [ENTRIES-1:0]  upd_sel,
    input  logic [PC_W-1:0]     wr_pc,
    input  logic [PC_W-1:0]     wr_target,
    input  logic                wr_taken,
    output logic [PC_W-1:0]     tags    [ENTRIES],
    output logic [PC_W-1:0]     targets [ENTRIES],
    output bht_pkg::hist_t      hist    [ENTRIES],
    output logic [ENTRIES-1:0]  valid
);
    import bht_pkg::*;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        // Write one slot: fill on allocation, train on a hit update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[i]   <= 1'b0;
                tags[i]    <= '0;
                targets[i] <= '0;
                hist[i]    <= HIST_WNT;
            end else if (alloc_sel[i]) begin
                valid[i]   <= 1'b1;
                tags[i]    <= wr_pc;
                targets[i] <= wr_target;
                hist[i]    <= hist_seed(wr_taken);
            end else if (upd_sel[i]) begin
                targets[i] <= wr_target;
                hist[i]    <= hist_step(hist[i], wr_taken);
            end
        end

        assert_sat_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_sel[i] && wr_taken && hist[i] != HIST_ST)
                |=> hist[i] == $past(hist[i]) + 2'd1);

        assert_sat_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_sel[i] && !wr_taken && hist[i] != HIST_SNT)
                |=> hist[i] == $past(hist[i]) - 2'd1);

        assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_sel[i] && ((wr_taken && hist[i] == HIST_ST) ||
                            (!wr_taken && hist[i] == HIST_SNT)))
                |=> $stable(hist[i]));

        assert_alloc_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_sel[i] |=> valid[i] && tags[i] == $past(wr_pc) &&
                hist[i] == ($past(wr_taken) ? HIST_WT : HIST_WNT));

        assert_target_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
            upd_sel[i] |=> targets[i] == $past(wr_target));
    end

endmodule

// File: rtl/branch_history_predictor.sv
// Branch history table with target storage for the fetch stage.
// Lookup is combinational from registered slot state, so a same-cycle
// update is seen by lookups only from the next cycle on. Misses on the
// update port allocate at a round-robin pointer. Assumes ENTRIES >= 2.
module branch_history_predictor #(
    parameter int ENTRIES = 8,
    parameter int PC_W    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic [PC_W-1:0] res_target,
    input  logic            res_taken
);
    import bht_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    logic [PC_W-1:0]    tags    [ENTRIES];
    logic [PC_W-1:0]    targets [ENTRIES];
    hist_t              hist    [ENTRIES];
    logic [ENTRIES-1:0] valid;
    logic [ENTRIES-1:0] look_vec;
    logic [ENTRIES-1:0] res_vec;
    logic [ENTRIES-1:0] alloc_sel;
    logic [ENTRIES-1:0] upd_sel;
    logic [IDX_W-1:0]   victim;
    logic               do_alloc;

    bht_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_look_match (
        .addr(fetch_pc), .tags(tags), .valid(valid), .hit_vec(look_vec));

    bht_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_res_match (
        .addr(res_pc), .tags(tags), .valid(valid), .hit_vec(res_vec));

    assign do_alloc = res_valid && (res_vec == '0);

    bht_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .advance(do_alloc), .ptr(victim));

    // Turn the update into per-slot write strobes.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            alloc_sel[i] = do_alloc && (victim == IDX_W'(i));
            upd_sel[i]   = res_valid && res_vec[i];
        end
    end

    bht_store #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .alloc_sel(alloc_sel), .upd_sel(upd_sel),
        .wr_pc(res_pc), .wr_target(res_target), .wr_taken(res_taken),
        .tags(tags), .targets(targets), .hist(hist), .valid(valid));

    // Select the matching slot's target and direction for fetch.
    always_comb begin
        pred_hit    = |look_vec;
        pred_taken  = 1'b0;
        pred_target = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_vec[i]) begin
                pred_taken  = pred_taken | hist[i][1];
                pred_target = pred_target | targets[i];
            end
        end
    end

    assert_single_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_vec) && $onehot0(res_vec));

    assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> !pred_taken && pred_target == '0);

    assert_one_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_sel) && ((alloc_sel & upd_sel) == '0));

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> valid == '0);

endmodule

// File: tb/sim_branch_history_predictor.sv
`timescale 1ns/1ps
module sim_branch_history_predictor;

    localparam int N  = 4;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] fetch_pc = '0;
    logic          pred_hit, pred_taken;
    logic [PW-1:0] pred_target;
    logic          res_valid = 1'b0;
    logic [PW-1:0] res_pc = '0, res_target = '0;
    logic          res_taken = 1'b0;

    int tests = 0;
    int fails = 0;

    // model of the table, built from the requirements
    logic          m_valid [N];
    logic [PW-1:0] m_tag   [N];
    logic [PW-1:0] m_tgt   [N];
    int            m_ctr   [N];
    int            m_ptr;

    always #4 clk = ~clk;

    branch_history_predictor #(.ENTRIES(N), .PC_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
        .res_valid(res_valid), .res_pc(res_pc), .res_target(res_target),
        .res_taken(res_taken));

    function automatic int find(input logic [PW-1:0] pc);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_tag[i] == pc) return i;
        return -1;
    endfunction

    task automatic model_update(input logic [PW-1:0] pc, input logic [PW-1:0] tg, input logic tk);
        int k;
        k = find(pc);
        if (k >= 0) begin
            m_tgt[k] = tg;
            if (tk) m_ctr[k] = (m_ctr[k] == 3) ? 3 : m_ctr[k] + 1;
            else    m_ctr[k] = (m_ctr[k] == 0) ? 0 : m_ctr[k] - 1;
        end else begin
            m_valid[m_ptr] = 1'b1;
            m_tag[m_ptr]   = pc;
            m_tgt[m_ptr]   = tg;
            m_ctr[m_ptr]   = tk ? 2 : 1;
            m_ptr          = (m_ptr + 1) % N;
        end
    endtask

    // compare the lookup outputs for the address currently on fetch_pc
    task automatic check_now(input string req);
        int k;
        logic e_hit, e_tk;
        logic [PW-1:0] e_tg;
        k = find(fetch_pc);
        e_hit = (k >= 0);
        e_tk  = e_hit ? (m_ctr[k] >= 2) : 1'b0;
        e_tg  = e_hit ? m_tgt[k] : '0;
        tests++;
        if (pred_hit !== e_hit || pred_taken !== e_tk || pred_target !== e_tg) begin
            fails++;
            $display("FAIL %s pc=%h got hit=%b tk=%b tg=%h exp hit=%b tk=%b tg=%h",
                     req, fetch_pc, pred_hit, pred_taken, pred_target, e_hit, e_tk, e_tg);
        end
    endtask

    task automatic look(input logic [PW-1:0] pc, input string req);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        check_now(req);
    endtask

    task automatic resolve(input logic [PW-1:0] pc, input logic [PW-1:0] tg, input logic tk);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_target = tg; res_taken = tk;
        @(posedge clk);
        model_update(pc, tg, tk);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic sweep_all(input string req);
        for (int a = 0; a < 256; a++) look(PW'(a), req);
    endtask

    // fixed outcome pattern walking the counter through every state
    localparam logic [12:0] PAT = 13'b1011000010111;

    initial begin
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 1;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset across the whole address space
        sweep_all("R1");

        // R3: allocation seeds weak states, R2 unrelated address misses
        resolve(8'h20, 8'h80, 1'b1);
        look(8'h20, "R3");
        resolve(8'h24, 8'h90, 1'b0);
        look(8'h24, "R3");
        look(8'h28, "R2");

        // R4/R5: walk one branch through a long pattern, check each step
        for (int s = 0; s < 13; s++) begin
            resolve(8'h20, 8'h80, PAT[s]);
            look(8'h20, "R4_R5");
        end

        // R6: drive to strong taken, then two disagreeing outcomes
        resolve(8'h20, 8'h80, 1'b1);
        resolve(8'h20, 8'h80, 1'b1);
        resolve(8'h20, 8'h80, 1'b0);
        look(8'h20, "R6");
        tests++;
        if (pred_taken !== 1'b1) begin
            fails++; $display("FAIL R6 after one miss got tk=%b exp 1", pred_taken);
        end
        resolve(8'h20, 8'h80, 1'b0);
        look(8'h20, "R6");
        tests++;
        if (pred_taken !== 1'b0) begin
            fails++; $display("FAIL R6 after two misses got tk=%b exp 0", pred_taken);
        end

        // R9: hit update replaces the target
        resolve(8'h20, 8'h55, 1'b1);
        look(8'h20, "R9");

        // R7: fill remaining slots, wrap, evict the oldest
        resolve(8'h30, 8'hA0, 1'b1);
        resolve(8'h34, 8'hA4, 1'b0);
        resolve(8'h38, 8'hA8, 1'b1);
        look(8'h20, "R7");
        tests++;
        if (pred_hit !== 1'b0) begin
            fails++; $display("FAIL R7 evicted branch got hit=%b exp 0", pred_hit);
        end
        look(8'h38, "R7");
        resolve(8'h3C, 8'hAC, 1'b1);
        look(8'h24, "R7");

        // R8: lookup and update of one branch in the same cycle
        @(negedge clk);
        fetch_pc = 8'h30;
        res_valid = 1'b1; res_pc = 8'h30; res_target = 8'hB0; res_taken = 1'b0;
        #2;
        check_now("R8");
        @(posedge clk);
        model_update(8'h30, 8'hB0, 1'b0);
        #1;
        check_now("R8");
        @(negedge clk) res_valid = 1'b0;

        // R10/R2: full sweep against the model
        sweep_all("R10");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule